// File: doc/BRIEF.md
# Boost Overvoltage Fault Averager

This block guards the bulk capacitor behind a power-factor boost stage. It receives digitized samples of the boost output voltage and compares each accepted sample against an overvoltage limit. The limit depends on the line range. Each over-limit sample raises a saturating history counter and each clean sample lowers it. When the history reaches its trip level, the block removes the boost enable. The trip level is sized so the voltage can stay above the limit for no more than 1.6 ms. While the boost is off, the block forces the downstream converter's dim command to full scale, so that stage bleeds the stored energy off the capacitor. A fault flag is raised for as long as the hold lasts. The boost returns only after a sample at or below a lower recovery level. At that point the history is wiped.

Samples arrive on a valid/ready stream. `smp_ready` is low during reset and rises on the first clock after reset release. It never falls again, so the block applies no back-pressure. A sample counts only in a cycle where both `smp_valid` and `smp_ready` are high. A source may present samples back to back or with gaps of any length. The line-range select is captured in the last reset cycle and held until the next reset.

Top module: `boost_ovp_averager`

## Requirements
- R1: During reset `boost_en`=1, `dim_full`=0, `ovp_fault`=0 and `smp_ready`=0. On the first clock after reset release, `smp_ready` becomes 1.
- R2: The code has 0.5 V per LSB. An accepted sample counts as a fault when its code is strictly above 498 (249 V) in low-line mode (`hi_line`=0), or strictly above 896 (448 V) in high-line mode (`hi_line`=1). A sample exactly at the limit counts as clean.
- R3: The history counter adds 2 for a fault sample and subtracts 1 for a clean sample. The trip level is 320. From an empty history, 159 consecutive fault samples leave the boost enabled, and the 160th trips it (160 samples of 10 us is 1.6 ms).
- R4: The trip takes effect on the clock edge that accepts the tripping sample. From then on, `boost_en`=0, `dim_full`=1 and `ovp_fault`=1.
- R5: While tripped, an accepted sample at or below 390 (195 V, low-line) or 736 (368 V, high-line) restores `boost_en`=1, `dim_full`=0 and `ovp_fault`=0 at that edge. A sample above the recovery level keeps the block tripped.
- R6: Re-enabling the boost clears the history. After recovery, 159 fault samples do not trip again and the 160th does.
- R7: Cycles without an accepted sample change neither the outputs nor the history, whatever `smp_code` holds.
- R8: The line range is latched in the last reset cycle. Changing `hi_line` after reset release has no effect until the next reset.
- R9: The history floors at zero. Any number of clean samples on an empty history still leaves exactly 160 fault samples needed to trip.
- R10: Alternating fault and clean samples gain a net 1 per pair. From an empty history, the trip happens on the 637th sample (the fault sample of the 319th pair), and not after 636 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_line | input | 1 | Line-range select, 1 = high-line thresholds; captured during reset |
| smp_valid | input | 1 | Voltage sample valid |
| smp_ready | output | 1 | Block accepts samples; high from the first cycle after reset |
| smp_code | input | 10 | Boost output voltage code, unsigned, 0.5 V per LSB |
| boost_en | output | 1 | Boost stage enable |
| dim_full | output | 1 | Forces the downstream dim command to full scale |
| ovp_fault | output | 1 | Overvoltage hold in progress |

## Verification
The assertions assume that `hi_line` can be sampled during reset. They also assume that `smp_code` is meaningful only when `smp_valid` is high, so they qualify every threshold relation with an accepted transfer. The stimulus changes `smp_code` and `smp_valid` only on falling edges. It holds `hi_line` steady through each reset and moves it only afterwards, to show that it is ignored. It leaves garbage on `smp_code` while `smp_valid` is low, to exercise the no-transfer path.

// File: rtl/bovp_pkg.sv
package bovp_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } bovp_state_e;

  // converts a millivolt level into an ADC code for a given LSB size
  function automatic int mv_to_code(input int mv, input int lsb_mv);
    return mv / lsb_mv;
  endfunction

endpackage

// File: rtl/bovp_thresh.sv
module bovp_thresh #(
  parameter int CODE_W       = 10,
  parameter int LO_TRIP_CODE = 498,
  parameter int LO_REC_CODE  = 390,
  parameter int HI_TRIP_CODE = 896,
  parameter int HI_REC_CODE  = 736
) (
  input  logic [CODE_W-1:0] smp_code,
  input  logic              hi_sel,
  output logic              over,
  output logic              low_ok
);
  localparam logic [CODE_W-1:0] LO_TRIP = LO_TRIP_CODE[CODE_W-1:0];
  localparam logic [CODE_W-1:0] LO_REC  = LO_REC_CODE[CODE_W-1:0];
  localparam logic [CODE_W-1:0] HI_TRIP = HI_TRIP_CODE[CODE_W-1:0];
  localparam logic [CODE_W-1:0] HI_REC  = HI_REC_CODE[CODE_W-1:0];

  logic [CODE_W-1:0] trip_lvl;
  logic [CODE_W-1:0] rec_lvl;

  always_comb begin
    trip_lvl = hi_sel ? HI_TRIP : LO_TRIP;
    rec_lvl  = hi_sel ? HI_REC  : LO_REC;
    over     = smp_code > trip_lvl;   // strict: at-limit is clean
    low_ok   = smp_code <= rec_lvl;
  end
endmodule

// File: rtl/bovp_avg.sv
module bovp_avg #(
  parameter int TRIP_LVL = 320,
  parameter int UP_STEP  = 2,
  parameter int DN_STEP  = 1,
  parameter int CNT_W    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic fault,
  input  logic clear,
  output logic trip
);
  localparam logic [CNT_W-1:0] TRIP_C = TRIP_LVL[CNT_W-1:0];
  localparam logic [CNT_W-1:0] UP_C   = UP_STEP[CNT_W-1:0];
  localparam logic [CNT_W-1:0] DN_C   = DN_STEP[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] sum;

  always_comb begin
    sum   = cnt_q + UP_C;
    cnt_d = cnt_q;
    trip  = 1'b0;
    if (step_en) begin
      if (fault) begin
        if (sum >= TRIP_C) begin
          cnt_d = TRIP_C;
          trip  = 1'b1;
        end else begin
          cnt_d = sum;
        end
      end else begin
        cnt_d = (cnt_q >= DN_C) ? (cnt_q - DN_C) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else                 cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bovp_ctrl.sv
module bovp_ctrl
  import bovp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hi_line,
  input  logic acc,
  input  logic trip,
  input  logic low_ok,
  output logic hi_sel,
  output logic step_en,
  output logic clear,
  output logic smp_ready,
  output logic boost_en,
  output logic dim_full,
  output logic ovp_fault
);
  bovp_state_e state_q, state_d;
  logic hi_q, rdy_q, en_q, dim_q, flt_q;

  always_comb begin
    step_en = acc && (state_q == ST_RUN);
    clear   = acc && (state_q == ST_HOLD) && low_ok;
    state_d = state_q;
    if (step_en && trip) state_d = ST_HOLD;
    else if (clear)      state_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      hi_q    <= hi_line;   // range captured while reset is held
      rdy_q   <= 1'b0;
      en_q    <= 1'b1;
      dim_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= 1'b1;
      en_q    <= (state_d == ST_RUN);
      dim_q   <= (state_d == ST_HOLD);
      flt_q   <= (state_d == ST_HOLD);
    end
  end

  assign hi_sel    = hi_q;
  assign smp_ready = rdy_q;
  assign boost_en  = en_q;
  assign dim_full  = dim_q;
  assign ovp_fault = flt_q;
endmodule

// File: rtl/boost_ovp_averager.sv
module boost_ovp_averager
  import bovp_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int LSB_MV     = 500,
  parameter int LO_TRIP_MV = 249000,
  parameter int LO_REC_MV  = 195000,
  parameter int HI_TRIP_MV = 448000,
  parameter int HI_REC_MV  = 368000,
  parameter int SAMPLE_NS  = 10000,
  parameter int BOUND_NS   = 1600000,
  parameter int UP_STEP    = 2,
  parameter int DN_STEP    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_line,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CODE_W-1:0] smp_code,
  output logic              boost_en,
  output logic              dim_full,
  output logic              ovp_fault
);
  localparam int LO_TRIP_CODE = mv_to_code(LO_TRIP_MV, LSB_MV);
  localparam int LO_REC_CODE  = mv_to_code(LO_REC_MV, LSB_MV);
  localparam int HI_TRIP_CODE = mv_to_code(HI_TRIP_MV, LSB_MV);
  localparam int HI_REC_CODE  = mv_to_code(HI_REC_MV, LSB_MV);
  localparam int BOUND_SMP    = BOUND_NS / SAMPLE_NS;
  localparam int TRIP_LVL     = UP_STEP * BOUND_SMP;
  localparam int CNT_W        = $clog2(TRIP_LVL + UP_STEP + 1);

  logic acc, hi_sel, over, low_ok, step_en, clear, trip;

  assign acc = smp_valid && smp_ready;

  bovp_thresh #(
    .CODE_W(CODE_W), .LO_TRIP_CODE(LO_TRIP_CODE), .LO_REC_CODE(LO_REC_CODE),
    .HI_TRIP_CODE(HI_TRIP_CODE), .HI_REC_CODE(HI_REC_CODE)
  ) u_thresh (
    .smp_code(smp_code), .hi_sel(hi_sel), .over(over), .low_ok(low_ok)
  );

  bovp_avg #(
    .TRIP_LVL(TRIP_LVL), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP), .CNT_W(CNT_W)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .fault(over),
    .clear(clear), .trip(trip)
  );

  bovp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_line(hi_line), .acc(acc), .trip(trip),
    .low_ok(low_ok), .hi_sel(hi_sel), .step_en(step_en), .clear(clear),
    .smp_ready(smp_ready), .boost_en(boost_en), .dim_full(dim_full),
    .ovp_fault(ovp_fault)
  );
endmodule

// File: rtl/bovp_checker.sv
module bovp_checker #(
  parameter int CODE_W       = 10,
  parameter int LO_TRIP_CODE = 498,
  parameter int LO_REC_CODE  = 390,
  parameter int HI_TRIP_CODE = 896,
  parameter int HI_REC_CODE  = 736,
  parameter int TRIP_LVL     = 320,
  parameter int CNT_W        = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [CODE_W-1:0] smp_code,
  input logic              hi_sel,
  input logic              boost_en,
  input logic              dim_full,
  input logic              ovp_fault,
  input logic [CNT_W-1:0]  cnt
);
  logic [CODE_W-1:0] trip_c, rec_c;
  logic acc;
  assign trip_c = hi_sel ? HI_TRIP_CODE[CODE_W-1:0] : LO_TRIP_CODE[CODE_W-1:0];
  assign rec_c  = hi_sel ? HI_REC_CODE[CODE_W-1:0]  : LO_REC_CODE[CODE_W-1:0];
  assign acc    = smp_valid && smp_ready;

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> smp_ready);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TRIP_LVL[CNT_W-1:0]);

  a_r4_trip_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boost_en) |-> $past(acc && (smp_code > trip_c)));

  a_r4_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !boost_en |-> (dim_full && ovp_fault));

  a_r5_recover_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> $past(acc && (smp_code <= rec_c)));

  a_r6_clear_on_recover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> (cnt == '0));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(boost_en) && $stable(cnt)));

  a_r8_range_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(hi_sel));
endmodule

bind boost_ovp_averager bovp_checker #(
  .CODE_W(CODE_W), .LO_TRIP_CODE(LO_TRIP_CODE), .LO_REC_CODE(LO_REC_CODE),
  .HI_TRIP_CODE(HI_TRIP_CODE), .HI_REC_CODE(HI_REC_CODE),
  .TRIP_LVL(TRIP_LVL), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_code(smp_code), .hi_sel(hi_sel), .boost_en(boost_en),
  .dim_full(dim_full), .ovp_fault(ovp_fault), .cnt(u_avg.cnt_q)
);

// File: tb/boost_ovp_averager_bench.sv
module boost_ovp_averager_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_line = 1'b0;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_code = '0;
  logic       smp_ready, boost_en, dim_full, ovp_fault;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  boost_ovp_averager u_boost_ovp_averager (
    .clk(clk), .rst_n(rst_n), .hi_line(hi_line), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_code(smp_code), .boost_en(boost_en),
    .dim_full(dim_full), .ovp_fault(ovp_fault)
  );

  typedef struct packed {
    logic        do_rst;
    logic        hi;
    logic [9:0]  code;
    logic [11:0] reps;
    logic        exp_en;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 10'd498, 12'd400, 1'b1},  // R2 at-limit clean, low line
    '{1'b0, 1'b0, 10'd499, 12'd159, 1'b1},  // R3 one short of trip
    '{1'b0, 1'b0, 10'd499, 12'd1,   1'b0},  // R4 trip
    '{1'b0, 1'b0, 10'd391, 12'd5,   1'b0},  // R5 above recovery
    '{1'b0, 1'b0, 10'd390, 12'd1,   1'b1},  // R5 recover
    '{1'b0, 1'b0, 10'd499, 12'd159, 1'b1},  // R6 history cleared
    '{1'b0, 1'b0, 10'd499, 12'd1,   1'b0},  // R6 trips again
    '{1'b1, 1'b1, 10'd896, 12'd200, 1'b1},  // R2 at-limit clean, high line
    '{1'b0, 1'b1, 10'd897, 12'd159, 1'b1},  // R3 high line
    '{1'b0, 1'b1, 10'd897, 12'd1,   1'b0},  // R4 high line
    '{1'b0, 1'b1, 10'd737, 12'd3,   1'b0},  // R5 high line hold
    '{1'b0, 1'b1, 10'd736, 12'd1,   1'b1}   // R5 high line recover
  };

  function automatic string vtag(input int i);
    case (i)
      0, 7:     return "R2";
      1, 8:     return "R3";
      2, 9:     return "R4";
      5, 6:     return "R6";
      default:  return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ready,en,dim,fault} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_en);
    chk(req, {smp_ready, boost_en, dim_full, ovp_fault}, {1'b1, exp_en, ~exp_en, ~exp_en});
  endtask

  task automatic do_reset(input logic hi);
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    hi_line = hi;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {smp_ready, boost_en, dim_full, ovp_fault}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", {smp_ready, boost_en, dim_full, ovp_fault}, 4'b1100);
  endtask

  task automatic send(input logic [9:0] code, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_code = code;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    smp_code = 10'h3ff;   // garbage while idle
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_rst) do_reset(VECS[i].hi);
      send(VECS[i].code, int'(VECS[i].reps));
      chk_out(vtag(i), VECS[i].exp_en);
    end

    // R7: invalid cycles carrying over-limit codes are ignored
    do_reset(1'b0);
    @(negedge clk);
    smp_code = 10'd1000;
    repeat (500) @(negedge clk);
    chk_out("R7 idle over-limit code", 1'b1);
    send(10'd1000, 159);
    chk_out("R7 no hidden history", 1'b1);
    send(10'd1000, 1);
    chk_out("R7 trips on 160th", 1'b0);
    @(negedge clk);
    smp_code = 10'd0;
    repeat (20) @(negedge clk);
    chk_out("R7 stays tripped without samples", 1'b0);

    // R8: range latched in reset, later change ignored
    do_reset(1'b0);
    @(negedge clk);
    hi_line = 1'b1;
    send(10'd600, 160);
    chk_out("R8 low-line limit kept", 1'b0);
    send(10'd700, 1);   // below 736 but above 390
    chk_out("R8 low-line recovery kept", 1'b0);
    do_reset(1'b1);
    @(negedge clk);
    hi_line = 1'b0;
    send(10'd600, 200);
    chk_out("R8 high-line limit kept", 1'b1);

    // R9: floor at zero
    do_reset(1'b0);
    send(10'd0, 300);
    chk_out("R9 clean run", 1'b1);
    send(10'd510, 159);
    chk_out("R9 159 after floor", 1'b1);
    send(10'd510, 1);
    chk_out("R9 160th trips", 1'b0);

    // R10: alternating pattern
    do_reset(1'b0);
    for (int p = 0; p < 318; p++) begin
      send(10'd600, 1);
      send(10'd100, 1);
    end
    chk_out("R10 after 636 samples", 1'b1);
    send(10'd600, 1);
    chk_out("R10 trips at 637th", 1'b0);

    summary();
  end
endmodule